// File: doc/BRIEF.md
# Flash Program and Poll Sequencer

This block sits on the host side of a byte-wide parallel flash device. A client hands it one request at a time: program a single byte, erase the whole device, switch the device into unlock-bypass mode, or switch it back out. The block turns each request into the unlock and command write cycles the device expects. For a program or an erase it then polls the device's status through a simple synchronous bus master, decides pass or fail, and reports the outcome with a one-cycle completion pulse.

Status polling looks at the data-poll bit (bit 7) and the error bit (bit 5) read back from the target address. Once the error bit is seen, the block reads one more time before it declares failure, because the device can update both bits in the same read. After any failed operation the block writes the device's reset command, so the device is back in a readable state when the client sees the failure. A poll-read budget, given on a control input, stops the block from waiting forever on a device that never finishes.

The request side uses a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While an operation is in progress the block applies back-pressure by holding `req_ready` low. Requests cannot be queued.

Top module: `flash_pgm_ctrl`

## Requirements
- R1: `req_ready` is high only in idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge, and `req_ready` stays low from that edge until the cycle after `done`.
- R2: Operation codes on `req_op` are 00 = program byte, 01 = erase device, 10 = enter bypass, 11 = leave bypass. In normal mode, a program request writes AAh@555h, then 55h@2AAh, then A0h@555h, then the request data at the request address.
- R3: An enter-bypass request writes AAh@555h, 55h@2AAh, 20h@555h. A leave-bypass request writes 90h@000h, then 00h@000h. Both finish with pass = 1 and perform no poll reads.
- R4: In bypass mode, a program request writes only A0h@000h, then the data at the target address.
- R5: An erase request writes AAh, 55h, 80h, AAh, 55h, 10h in that order, at 555h, 2AAh, 555h, 555h, 2AAh, 555h.
- R6: After the last write of a program or erase, the block reads the request address. If read bit 7 equals the expected bit, the operation passes. The expected bit is bit 7 of the data for a program and 1 for an erase.
- R7: If bit 7 mismatches and bit 5 is 1, the block makes exactly one more read of the same address. It passes if bit 7 now matches; otherwise it fails.
- R8: On any failure of a program or erase, the block writes F0h@000h before it pulses `done` with pass = 0. Bypass mode is unchanged by this reset write.
- R9: If bit 7 mismatches and bit 5 is 0, the block reads again. Reaching `poll_limit` such reads (a limit of 0 acts as 1) without a pass counts as a failure.
- R10: A request that does not fit the current mode completes with `done` and pass = 0, with no bus access. In bypass mode, erase and enter-bypass are rejected. In normal mode, leave-bypass is rejected.
- R11: `done` is high for exactly one cycle per request. While `bus_req` is high and `bus_ack` is low, `bus_we`, `bus_addr` and `bus_wdata` hold their values.
- R12: After reset, `req_ready` = 1, `bus_req` = 0, `done` = 0, and the block is in normal (non-bypass) mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_op | input | 2 | Operation code |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | DATA_W | Byte to program |
| poll_limit | input | TMO_W | Maximum plain poll reads before failure |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Outcome of the last request, valid with `done` |
| bus_req | output | 1 | Bus access requested |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Access complete; read data valid |
| bus_rdata | input | DATA_W | Read data |

## Verification
The bench uses the default byte width and a 16-bit address, so it can see the unlock addresses and targets at both ends of the range. It narrows `TMO_W` to 8 and sets `poll_limit` to 3, which makes poll-budget expiry happen after three reads. It then drives status responses that take each polling branch: an immediate match, a slow match, a recovery on the second read after bit 5 is set, a failure on that second read, and expiry of the budget. These runs happen in both normal and bypass mode, so the reset write and the persistence of bypass mode after a failure are both exercised.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;

  typedef enum logic [1:0] {
    OP_PROG    = 2'b00,
    OP_ERASE   = 2'b01,
    OP_BYP_ON  = 2'b10,
    OP_BYP_OFF = 2'b11
  } fop_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_POLL,
    ST_RECHK,
    ST_ABORT,
    ST_DONE
  } fst_t;

  localparam int unsigned STEP_W = 3;

  localparam logic [10:0] UNLK_A1 = 11'h555;
  localparam logic [10:0] UNLK_A2 = 11'h2AA;

  localparam logic [7:0] CB_KEY1   = 8'hAA;
  localparam logic [7:0] CB_KEY2   = 8'h55;
  localparam logic [7:0] CB_PROG   = 8'hA0;
  localparam logic [7:0] CB_ERSETP = 8'h80;
  localparam logic [7:0] CB_ERSGO  = 8'h10;
  localparam logic [7:0] CB_BYPON  = 8'h20;
  localparam logic [7:0] CB_BYPX1  = 8'h90;
  localparam logic [7:0] CB_BYPX2  = 8'h00;
  localparam logic [7:0] CB_RESET  = 8'hF0;

  function automatic logic op_legal(input fop_t op, input logic byp);
    case (op)
      OP_PROG:    op_legal = 1'b1;
      OP_ERASE:   op_legal = !byp;
      OP_BYP_ON:  op_legal = !byp;
      OP_BYP_OFF: op_legal = byp;
      default:    op_legal = 1'b0;
    endcase
  endfunction

  function automatic logic op_polls(input fop_t op);
    op_polls = (op == OP_PROG) || (op == OP_ERASE);
  endfunction

endpackage

// File: rtl/fpc_cmd_table.sv
module fpc_cmd_table
  import flash_pgm_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  fop_t               op,
  input  logic               byp,
  input  logic [STEP_W-1:0]  step,
  input  logic [ADDR_W-1:0]  tgt_addr,
  input  logic [DATA_W-1:0]  tgt_data,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [DATA_W-1:0]  cmd_data,
  output logic               last_step
);

  localparam logic [ADDR_W-1:0] A1   = ADDR_W'(UNLK_A1);
  localparam logic [ADDR_W-1:0] A2   = ADDR_W'(UNLK_A2);
  localparam logic [ADDR_W-1:0] AZ   = '0;

  logic [STEP_W-1:0] seq_len;

  always_comb begin
    cmd_addr = AZ;
    cmd_data = '0;
    seq_len  = STEP_W'(1);
    case (op)
      OP_PROG: begin
        if (byp) begin
          seq_len = STEP_W'(2);
          case (step)
            3'd0:    begin cmd_addr = AZ;       cmd_data = DATA_W'(CB_PROG); end
            default: begin cmd_addr = tgt_addr; cmd_data = tgt_data;         end
          endcase
        end else begin
          seq_len = STEP_W'(4);
          case (step)
            3'd0:    begin cmd_addr = A1;       cmd_data = DATA_W'(CB_KEY1); end
            3'd1:    begin cmd_addr = A2;       cmd_data = DATA_W'(CB_KEY2); end
            3'd2:    begin cmd_addr = A1;       cmd_data = DATA_W'(CB_PROG); end
            default: begin cmd_addr = tgt_addr; cmd_data = tgt_data;         end
          endcase
        end
      end
      OP_ERASE: begin
        seq_len = STEP_W'(6);
        case (step)
          3'd0:    begin cmd_addr = A1; cmd_data = DATA_W'(CB_KEY1);   end
          3'd1:    begin cmd_addr = A2; cmd_data = DATA_W'(CB_KEY2);   end
          3'd2:    begin cmd_addr = A1; cmd_data = DATA_W'(CB_ERSETP); end
          3'd3:    begin cmd_addr = A1; cmd_data = DATA_W'(CB_KEY1);   end
          3'd4:    begin cmd_addr = A2; cmd_data = DATA_W'(CB_KEY2);   end
          default: begin cmd_addr = A1; cmd_data = DATA_W'(CB_ERSGO);  end
        endcase
      end
      OP_BYP_ON: begin
        seq_len = STEP_W'(3);
        case (step)
          3'd0:    begin cmd_addr = A1; cmd_data = DATA_W'(CB_KEY1);  end
          3'd1:    begin cmd_addr = A2; cmd_data = DATA_W'(CB_KEY2);  end
          default: begin cmd_addr = A1; cmd_data = DATA_W'(CB_BYPON); end
        endcase
      end
      default: begin
        seq_len = STEP_W'(2);
        case (step)
          3'd0:    begin cmd_addr = AZ; cmd_data = DATA_W'(CB_BYPX1); end
          default: begin cmd_addr = AZ; cmd_data = DATA_W'(CB_BYPX2); end
        endcase
      end
    endcase
  end

  assign last_step = (step == seq_len - STEP_W'(1));

endmodule

// File: rtl/fpc_poll_judge.sv
module fpc_poll_judge #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned POLL_BIT = DATA_W - 1,
  parameter int unsigned ERR_BIT  = 5
) (
  input  logic [DATA_W-1:0] rd_data,
  input  logic              exp_bit,
  output logic              match,
  output logic              err_seen
);

  assign match    = (rd_data[POLL_BIT] == exp_bit);
  assign err_seen = rd_data[ERR_BIT];

endmodule

// File: rtl/fpc_poll_budget.sv
module fpc_poll_budget #(
  parameter int unsigned TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [TMO_W-1:0] limit,
  output logic             last_try
);

  logic [TMO_W-1:0] used_q;
  logic [TMO_W:0]   next_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      used_q <= '0;
    end else if (inc && used_q != {TMO_W{1'b1}}) begin
      used_q <= used_q + TMO_W'(1);
    end
  end

  assign next_cnt = {1'b0, used_q} + (TMO_W+1)'(1);
  assign last_try = (next_cnt >= {1'b0, limit});

endmodule

// File: rtl/flash_pgm_ctrl.sv
module flash_pgm_ctrl
  import flash_pgm_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TMO_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [TMO_W-1:0]  poll_limit,
  output logic              done,
  output logic              pass,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);

  fst_t              state_q;
  fop_t              op_q;
  fop_t              req_op_t;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STEP_W-1:0] step_q;
  logic              byp_q;
  logic              pass_q;

  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              last_step;
  logic              exp_bit;
  logic              rd_match;
  logic              rd_err;
  logic              budget_clr;
  logic              budget_inc;
  logic              budget_last;

  assign req_op_t = fop_t'(req_op);

  fpc_cmd_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_table (
    .op        (op_q),
    .byp       (byp_q),
    .step      (step_q),
    .tgt_addr  (addr_q),
    .tgt_data  (data_q),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .last_step (last_step)
  );

  assign exp_bit = (op_q == OP_ERASE) ? 1'b1 : data_q[DATA_W-1];

  fpc_poll_judge #(.DATA_W(DATA_W)) i_judge (
    .rd_data  (bus_rdata),
    .exp_bit  (exp_bit),
    .match    (rd_match),
    .err_seen (rd_err)
  );

  assign budget_clr = (state_q == ST_WRITE) && bus_ack && last_step;
  assign budget_inc = (state_q == ST_POLL) && bus_ack && !rd_match;

  fpc_poll_budget #(.TMO_W(TMO_W)) i_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (budget_clr),
    .inc      (budget_inc),
    .limit    (poll_limit),
    .last_try (budget_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      step_q  <= '0;
      byp_q   <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            op_q   <= req_op_t;
            addr_q <= req_addr;
            data_q <= req_data;
            step_q <= '0;
            if (op_legal(req_op_t, byp_q)) begin
              state_q <= ST_WRITE;
            end else begin
              pass_q  <= 1'b0;
              state_q <= ST_DONE;
            end
          end
        end
        ST_WRITE: begin
          if (bus_ack) begin
            if (!last_step) begin
              step_q <= step_q + STEP_W'(1);
            end else if (op_polls(op_q)) begin
              state_q <= ST_POLL;
            end else begin
              byp_q   <= (op_q == OP_BYP_ON);
              pass_q  <= 1'b1;
              state_q <= ST_DONE;
            end
          end
        end
        ST_POLL: begin
          if (bus_ack) begin
            if (rd_match) begin
              pass_q  <= 1'b1;
              state_q <= ST_DONE;
            end else if (rd_err) begin
              state_q <= ST_RECHK;
            end else if (budget_last) begin
              state_q <= ST_ABORT;
            end
          end
        end
        ST_RECHK: begin
          if (bus_ack) begin
            if (rd_match) begin
              pass_q  <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_ABORT;
            end
          end
        end
        ST_ABORT: begin
          if (bus_ack) begin
            pass_q  <= 1'b0;
            state_q <= ST_DONE;
          end
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state_q)
      ST_WRITE: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = cmd_addr;
        bus_wdata = cmd_data;
      end
      ST_POLL, ST_RECHK: begin
        bus_req  = 1'b1;
        bus_addr = addr_q;
      end
      ST_ABORT: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_wdata = DATA_W'(CB_RESET);
      end
      default: ;
    endcase
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign pass      = pass_q;

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack
);

  assert_idle_no_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req);

  assert_done_then_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)
                               && $stable(bus_wdata)));

  assert_done_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

endmodule

bind flash_pgm_ctrl fpc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done      (done),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ack   (bus_ack)
);

// File: tb/test_flash_pgm_ctrl.sv
`timescale 1ns/1ps
module test_flash_pgm_ctrl;

  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;
  localparam int unsigned TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [TW-1:0] poll_limit = TW'(3);
  logic          done, pass;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // expected bus item: {we, addr, data, tag}
  typedef struct { bit we; logic [AW-1:0] a; logic [DW-1:0] d; string tag; } bus_item_t;
  typedef struct { bit p; string tag; } res_item_t;
  bus_item_t     exp_bus_q[$];
  res_item_t     exp_res_q[$];
  logic [DW-1:0] rsp_q[$];

  always #4 clk = ~clk;

  flash_pgm_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TMO_W(TW)) i_flash_pgm_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .poll_limit(poll_limit), .done(done), .pass(pass),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // device model: one-cycle ack, read data from response queue
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (!bus_we) bus_rdata <= (rsp_q.size() > 0) ? rsp_q.pop_front() : 8'h00;
    end else begin
      bus_ack <= 1'b0;
    end
  end

  // monitor: bus transactions and results
  initial begin
    bus_item_t e;
    res_item_t r;
    forever begin
      @(negedge clk);
      if (rst_n && bus_req && bus_ack) begin
        if (exp_bus_q.size() == 0) begin
          chk(0, "R10 unexpected bus access", {bus_we, 7'd0, bus_addr, bus_wdata}, 32'h0);
        end else begin
          e = exp_bus_q.pop_front();
          chk(bus_we == e.we, e.tag, bus_we, e.we);
          chk(bus_addr == e.a, e.tag, bus_addr, e.a);
          if (e.we) chk(bus_wdata == e.d, e.tag, bus_wdata, e.d);
        end
      end
      if (rst_n && done) begin
        if (exp_res_q.size() == 0) begin
          chk(0, "R1 unexpected done", 1, 0);
        end else begin
          r = exp_res_q.pop_front();
          chk(pass == r.p, r.tag, pass, r.p);
        end
        @(negedge clk);
        chk(!done, "R11 done width", done, 0);
      end
    end
  end

  task automatic ew(input logic [AW-1:0] a, input logic [DW-1:0] d, input string t);
    bus_item_t e;
    e.we = 1; e.a = a; e.d = d; e.tag = t;
    exp_bus_q.push_back(e);
  endtask

  task automatic er(input logic [AW-1:0] a, input logic [DW-1:0] rsp, input string t);
    bus_item_t e;
    e.we = 0; e.a = a; e.d = '0; e.tag = t;
    exp_bus_q.push_back(e);
    rsp_q.push_back(rsp);
  endtask

  task automatic eres(input bit p, input string t);
    res_item_t r;
    r.p = p; r.tag = t;
    exp_res_q.push_back(r);
  endtask

  task automatic unlock(input string t);
    ew(16'h0555, 8'hAA, t);
    ew(16'h02AA, 8'h55, t);
  endtask

  task automatic run(input logic [1:0] op, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input string t);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R1 ready low while busy", req_ready, 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk(exp_bus_q.size() == 0, {t, " bus sequence complete"}, exp_bus_q.size(), 0);
    chk(exp_res_q.size() == 0, {t, " result seen"}, exp_res_q.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(req_ready == 1'b1, "R12 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !bus_req && !done, "R12 idle after reset",
        {req_ready, bus_req, done}, 3'b100);

    // R12/R10: leave-bypass rejected in normal mode, no bus access
    eres(0, "R10 exit in normal mode");
    run(2'b11, 16'h0000, 8'h00, "R12 R10");

    // R2 R6: normal program, one busy read then match
    unlock("R2"); ew(16'h0555, 8'hA0, "R2"); ew(16'h1234, 8'h5A, "R2");
    er(16'h1234, 8'h80, "R6 busy read"); er(16'h1234, 8'h5A, "R6 match read");
    eres(1, "R6 program pass");
    run(2'b00, 16'h1234, 8'h5A, "R2");

    // R7: error bit, reread matches
    unlock("R2"); ew(16'h0555, 8'hA0, "R2"); ew(16'hFFFF, 8'hA5, "R2");
    er(16'hFFFF, 8'h20, "R7 err read"); er(16'hFFFF, 8'hA5, "R7 reread");
    eres(1, "R7 reread pass");
    run(2'b00, 16'hFFFF, 8'hA5, "R7");

    // R7 R8: reread still wrong -> reset write, fail
    unlock("R2"); ew(16'h0555, 8'hA0, "R2"); ew(16'h0001, 8'h81, "R2");
    er(16'h0001, 8'h20, "R7 err read"); er(16'h0001, 8'h20, "R7 reread");
    ew(16'h0000, 8'hF0, "R8 reset write");
    eres(0, "R8 fail after reread");
    run(2'b00, 16'h0001, 8'h81, "R8");

    // R5 R6: erase, expects bit7 = 1
    unlock("R5"); ew(16'h0555, 8'h80, "R5"); unlock("R5"); ew(16'h0555, 8'h10, "R5");
    er(16'h0800, 8'h00, "R6 erase busy"); er(16'h0800, 8'h40, "R6 erase busy");
    er(16'h0800, 8'hFF, "R6 erase done");
    eres(1, "R6 erase pass");
    run(2'b01, 16'h0800, 8'h00, "R5");

    // R9: budget of 3 plain reads
    unlock("R2"); ew(16'h0555, 8'hA0, "R2"); ew(16'h0042, 8'h00, "R2");
    er(16'h0042, 8'h80, "R9 read1"); er(16'h0042, 8'h80, "R9 read2");
    er(16'h0042, 8'h80, "R9 read3");
    ew(16'h0000, 8'hF0, "R8 reset after budget");
    eres(0, "R9 budget expiry fail");
    run(2'b00, 16'h0042, 8'h00, "R9");

    // R3: enter bypass
    unlock("R3"); ew(16'h0555, 8'h20, "R3");
    eres(1, "R3 enter pass");
    run(2'b10, 16'h0000, 8'h00, "R3");

    // R4: bypass program
    ew(16'h0000, 8'hA0, "R4"); ew(16'h0F00, 8'h11, "R4");
    er(16'h0F00, 8'h11, "R6 bypass match");
    eres(1, "R4 bypass program pass");
    run(2'b00, 16'h0F00, 8'h11, "R4");

    // R10: erase and enter rejected in bypass
    eres(0, "R10 erase in bypass");
    run(2'b01, 16'h0000, 8'h00, "R10 erase");
    eres(0, "R10 enter in bypass");
    run(2'b10, 16'h0000, 8'h00, "R10 enter");

    // R8: bypass failure, mode persists
    ew(16'h0000, 8'hA0, "R4"); ew(16'h0F01, 8'h11, "R4");
    er(16'h0F01, 8'hA0, "R7 err read"); er(16'h0F01, 8'hA0, "R7 reread");
    ew(16'h0000, 8'hF0, "R8 reset write");
    eres(0, "R8 bypass fail");
    run(2'b00, 16'h0F01, 8'h11, "R8 bypass");

    ew(16'h0000, 8'hA0, "R8 bypass kept"); ew(16'h0F02, 8'h80, "R8 bypass kept");
    er(16'h0F02, 8'h80, "R6 match");
    eres(1, "R4 second bypass program");
    run(2'b00, 16'h0F02, 8'h80, "R8 kept");

    // R3: leave bypass
    ew(16'h0000, 8'h90, "R3 exit"); ew(16'h0000, 8'h00, "R3 exit");
    eres(1, "R3 exit pass");
    run(2'b11, 16'h0000, 8'h00, "R3 exit");

    // R2: normal program again after exit, immediate match
    unlock("R2 after exit"); ew(16'h0555, 8'hA0, "R2 after exit");
    ew(16'h0300, 8'h7F, "R2 after exit");
    er(16'h0300, 8'h7F, "R6 match");
    eres(1, "R2 normal again pass");
    run(2'b00, 16'h0300, 8'h7F, "R2 again");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule